// File: doc/BRIEF.md
# Framed Byte SPI Slave with Handshake Bit

This block is an SPI slave that moves one byte per frame. Every frame lasts exactly twelve serial clock cycles. The master opens the frame with a start bit, then sends a direction bit and a register-select bit. Eight data bits follow, and the slave closes the frame with a single handshake bit. The master polls by repeating a frame until the handshake reports success.

A read frame sends a byte from a local transmit queue. The handshake marks that byte as fresh, or as a repeat of the previously returned byte. A write frame offers a byte to a local receive queue. The handshake reports whether the queue accepted the byte or refused it because the queue was full. The frame commits its queue operation only when it completes. If the select line drops mid-frame, the frame is abandoned and neither queue changes.

The serial inputs pass through synchronizers into a system clock that runs at least four times faster than the serial clock. Local logic fills the transmit queue and drains the receive queue through simple push and pop ports.

Top module: `spi12_slave`

## Requirements
- R1: After reset, `miso` is 0, `tx_full` is 0 and `rx_empty` is 1.
- R2: A frame begins only on a rising `sclk` edge that samples `ss`=1 and `mosi`=1. Rising edges with `ss`=0 or `mosi`=0 while idle are ignored. Rising edge 2 samples the direction (1 = read, 0 = write). Rising edge 3 samples the register select (0 = data queue, 1 = status byte). Edges 4 to 11 carry the 8 data bits, MSB first. Edge 12 ends the frame.
- R3: On a data read with a non-empty transmit queue, the head byte appears on `miso` MSB first: bit 7 is driven after edge 3 and bit 0 after edge 10. The handshake is 0, and the queue is popped once when the frame completes.
- R4: On a data read with an empty transmit queue, the byte last returned with handshake 0 is sent again (0x00 if none has been returned since reset). The handshake is 1, and the queue is not popped.
- R5: On a data write with room in the receive queue, the byte is pushed when the frame completes and the handshake is 0. Bytes leave `rx_rdata` in arrival order.
- R6: On a data write to a full receive queue, the handshake is 1 and the queue contents stay unchanged.
- R7: A status read returns a byte in which bit 0 is 1 when the transmit queue holds data and bit 1 is 1 when the receive queue is full; bits 7..2 are 0. The handshake is 0, and no queue is popped.
- R8: A write frame to the status select is refused with handshake 1 and pushes nothing.
- R9: The handshake is driven on `miso` after edge 11 and holds until edge 12. Outside an active frame, `miso` is 0.
- R10: If `ss` falls mid-frame, the frame ends, `miso` returns to 0 and no queue changes. The next frame runs normally.
- R11: A local push into a full transmit queue, or a local pop from an empty receive queue, is ignored. `tx_full` is 1 when the transmit queue holds DEPTH bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the master |
| ss | input | 1 | Frame select, high while a frame runs |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data and handshake to the master |
| tx_push | input | 1 | Local push into the transmit queue |
| tx_wdata | input | 8 | Byte to push into the transmit queue |
| tx_full | output | 1 | Transmit queue full |
| rx_pop | input | 1 | Local pop from the receive queue |
| rx_rdata | output | 8 | Head byte of the receive queue |
| rx_empty | output | 1 | Receive queue empty |

## Verification
The assertions check properties that must hold on every cycle:
- the frame bit counter stays in range;
- `miso` is quiet outside a frame;
- the handshake stays stable through its final cycle;
- a pop never hits an empty queue and a push never hits a full one;
- at most one queue operation is committed, and only on the completing edge;
- a dropped select always ends the frame.

The bench scenarios are needed to show the end-to-end results. These cover the actual byte values and their MSB-first order, the repeat of the last byte when the queue is empty, the content of the status byte, the arrival order of bytes in the receive queue, and the survival of queued data across aborted frames.

// File: rtl/spi12_pkg.sv
package spi12_pkg;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 4;

  // rising-edge numbers inside one frame
  localparam logic [CNT_W-1:0] EDGE_DIR       = 4'd2;
  localparam logic [CNT_W-1:0] EDGE_ADDR      = 4'd3;
  localparam logic [CNT_W-1:0] EDGE_LAST_DATA = 4'd11;
  localparam logic [CNT_W-1:0] FRAME_EDGES    = 4'd12;

  typedef enum logic { DIR_WRITE = 1'b0, DIR_READ = 1'b1 } dir_e;
  typedef enum logic { SEL_DATA = 1'b0, SEL_STAT = 1'b1 } sel_e;

  // bit of the outgoing byte driven after rising edge e (edge 3 -> bit 7)
  function automatic logic [2:0] rd_bit_index(input logic [CNT_W-1:0] e);
    return 3'(EDGE_LAST_DATA - 4'd1 - e);
  endfunction

  // status byte layout: bit0 tx has data, bit1 rx full
  function automatic logic [DATA_W-1:0] status_byte(input logic tx_avail,
                                                    input logic rx_full);
    return {{(DATA_W-2){1'b0}}, rx_full, tx_avail};
  endfunction
endpackage

// File: rtl/spi12_sync.sv
module spi12_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi12_fifo.sv
module spi12_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  output logic          full,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] level;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/spi12_frame.sv
module spi12_frame
  import spi12_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              ss_s,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] tx_head,
  input  logic              tx_empty,
  input  logic              rx_full,
  output logic              miso,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_byte,
  output logic              frame_active,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              evt_start,
  output logic              evt_abort,
  output logic              evt_done
);
  logic              sclk_d;
  logic              active_q;
  logic [CNT_W-1:0]  cnt_q, cnt_nx;
  dir_e              dir_q;
  sel_e              sel_q;
  logic [DATA_W-1:0] out_q, in_q, last_q;
  logic              stat_q, accept_q, fresh_q, miso_q;
  logic              rise, step;
  logic [DATA_W-1:0] ld_byte;
  logic              ld_fresh, ld_stat, wr_ok;

  assign rise      = sclk_s && !sclk_d;
  assign evt_start = rise && !active_q && ss_s && mosi_s;
  assign evt_abort = active_q && !ss_s;
  assign step      = rise && active_q && ss_s;
  assign cnt_nx    = cnt_q + 4'd1;
  assign evt_done  = step && (cnt_q == EDGE_LAST_DATA);
  assign tx_pop    = evt_done && (dir_q == DIR_READ) && (sel_q == SEL_DATA) && fresh_q;
  assign rx_push   = evt_done && (dir_q == DIR_WRITE) && accept_q;
  assign wr_ok     = (sel_q == SEL_DATA) && !rx_full;

  assign rx_byte      = in_q;
  assign miso         = miso_q;
  assign frame_active = active_q;
  assign bit_cnt      = cnt_q;

  // byte chosen for a read, decided on the select edge
  always_comb begin
    ld_byte  = last_q;
    ld_fresh = 1'b0;
    ld_stat  = 1'b1;
    if (sel_e'(mosi_s) == SEL_STAT) begin
      ld_byte = status_byte(!tx_empty, rx_full);
      ld_stat = 1'b0;
    end else if (!tx_empty) begin
      ld_byte  = tx_head;
      ld_fresh = 1'b1;
      ld_stat  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      active_q <= 1'b0;
      cnt_q    <= '0;
      dir_q    <= DIR_WRITE;
      sel_q    <= SEL_DATA;
      out_q    <= '0;
      in_q     <= '0;
      last_q   <= '0;
      stat_q   <= 1'b0;
      accept_q <= 1'b0;
      fresh_q  <= 1'b0;
      miso_q   <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      if (evt_abort) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
        miso_q   <= 1'b0;
      end else if (evt_start) begin
        active_q <= 1'b1;
        cnt_q    <= 4'd1;
        miso_q   <= 1'b0;
        fresh_q  <= 1'b0;
        accept_q <= 1'b0;
      end else if (step) begin
        if (cnt_nx == FRAME_EDGES) begin
          active_q <= 1'b0;
          cnt_q    <= '0;
          miso_q   <= 1'b0;
          if (tx_pop) last_q <= out_q;
        end else begin
          cnt_q <= cnt_nx;
          if (cnt_nx == EDGE_DIR) begin
            dir_q <= dir_e'(mosi_s);
          end else if (cnt_nx == EDGE_ADDR) begin
            sel_q <= sel_e'(mosi_s);
            if (dir_q == DIR_READ) begin
              out_q   <= ld_byte;
              fresh_q <= ld_fresh;
              stat_q  <= ld_stat;
              miso_q  <= ld_byte[DATA_W-1];
            end else begin
              miso_q <= 1'b0;
            end
          end else begin
            if (dir_q == DIR_WRITE) in_q <= {in_q[DATA_W-2:0], mosi_s};
            if (cnt_nx == EDGE_LAST_DATA) begin
              if (dir_q == DIR_READ) begin
                miso_q <= stat_q;
              end else begin
                accept_q <= wr_ok;
                miso_q   <= !wr_ok;
              end
            end else if (dir_q == DIR_READ) begin
              miso_q <= out_q[rd_bit_index(cnt_nx)];
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi12_slave.sv
module spi12_slave
  import spi12_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              ss,
  input  logic              mosi,
  output logic              miso,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_wdata,
  output logic              tx_full,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_rdata,
  output logic              rx_empty
);
  // named internal events, observed by the bound checker
  logic              sclk_sync, ss_sync, mosi_sync;
  logic [DATA_W-1:0] tx_head_w, rx_byte_w;
  logic              tx_empty_w, rx_full_w;
  logic              tx_pop_w, rx_push_w;
  logic              frame_active;
  logic [CNT_W-1:0]  bit_cnt;
  logic              evt_start, evt_abort, evt_done;

  spi12_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sclk, ss, mosi}),
    .q     ({sclk_sync, ss_sync, mosi_sync})
  );

  spi12_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (tx_push),
    .wdata (tx_wdata),
    .full  (tx_full),
    .pop   (tx_pop_w),
    .rdata (tx_head_w),
    .empty (tx_empty_w)
  );

  spi12_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rx_push_w),
    .wdata (rx_byte_w),
    .full  (rx_full_w),
    .pop   (rx_pop),
    .rdata (rx_rdata),
    .empty (rx_empty)
  );

  spi12_frame u_frame (
    .clk          (clk),
    .rst_n        (rst_n),
    .sclk_s       (sclk_sync),
    .ss_s         (ss_sync),
    .mosi_s       (mosi_sync),
    .tx_head      (tx_head_w),
    .tx_empty     (tx_empty_w),
    .rx_full      (rx_full_w),
    .miso         (miso),
    .tx_pop       (tx_pop_w),
    .rx_push      (rx_push_w),
    .rx_byte      (rx_byte_w),
    .frame_active (frame_active),
    .bit_cnt      (bit_cnt),
    .evt_start    (evt_start),
    .evt_abort    (evt_abort),
    .evt_done     (evt_done)
  );
endmodule

// File: rtl/spi12_chk.sv
module spi12_chk
  import spi12_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             miso,
  input logic             ss_sync,
  input logic             frame_active,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             tx_pop_w,
  input logic             rx_push_w,
  input logic             tx_empty_w,
  input logic             rx_full_w
);
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_active |-> (bit_cnt >= 4'd1 && bit_cnt <= EDGE_LAST_DATA)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_active |-> !miso); // R9
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_active && bit_cnt == EDGE_LAST_DATA &&
     $past(frame_active && bit_cnt == EDGE_LAST_DATA)) |-> $stable(miso)); // R9
  AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop_w |-> !tx_empty_w); // R4
  AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push_w |-> !rx_full_w); // R6
  AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({tx_pop_w, rx_push_w}) <= 1); // R5
  AST_COMMIT_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop_w || rx_push_w) |-> (frame_active && ss_sync && bit_cnt == EDGE_LAST_DATA)); // R10
  AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_active && !ss_sync) |=> !frame_active); // R10
endmodule

bind spi12_slave spi12_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .miso         (miso),
  .ss_sync      (ss_sync),
  .frame_active (frame_active),
  .bit_cnt      (bit_cnt),
  .tx_pop_w     (tx_pop_w),
  .rx_push_w    (rx_push_w),
  .tx_empty_w   (tx_empty_w),
  .rx_full_w    (rx_full_w)
);

// File: tb/sim_spi12_slave.sv
module sim_spi12_slave;
  localparam int HALF = 8;
  localparam int NV   = 10;
  // vector: op[19:18] (0 tx push, 1 spi read, 2 spi write, 3 rx pop),
  //         arg[17:10], expected byte[9:2], expected handshake[1], pad[0]
  localparam logic [19:0] VEC [NV] = '{
    {2'd1, 8'h00, 8'h00, 1'b1, 1'b0},  // R4 read on empty after reset
    {2'd0, 8'hA5, 8'h00, 1'b0, 1'b0},
    {2'd0, 8'h3C, 8'h00, 1'b0, 1'b0},
    {2'd1, 8'h00, 8'hA5, 1'b0, 1'b0},  // R3
    {2'd1, 8'h00, 8'h3C, 1'b0, 1'b0},  // R3
    {2'd1, 8'h00, 8'h3C, 1'b1, 1'b0},  // R4 repeat
    {2'd2, 8'h5A, 8'h00, 1'b0, 1'b0},  // R5
    {2'd2, 8'hC3, 8'h00, 1'b0, 1'b0},  // R5
    {2'd3, 8'h00, 8'h5A, 1'b0, 1'b0},  // R5 order
    {2'd3, 8'h00, 8'hC3, 1'b0, 1'b0}   // R5 order
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, ss = 1'b0, mosi = 1'b0;
  logic       miso;
  logic       tx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0] tx_wdata = 8'h00;
  logic       tx_full, rx_empty;
  logic [7:0] rx_rdata;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  spi12_slave u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .ss(ss), .mosi(mosi), .miso(miso),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_full(tx_full),
    .rx_pop(rx_pop), .rx_rdata(rx_rdata), .rx_empty(rx_empty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one frame; abort_at > 0 drops ss before that edge
  task automatic xfer(input bit rd, input bit sel, input logic [7:0] wb,
                      input int abort_at, output logic [7:0] rb,
                      output logic st, output logic st_hold);
    logic early;
    rb = 8'h00; st = 1'b0; early = 1'b0; st_hold = 1'b0;
    ss = 1'b1;
    for (int e = 1; e <= 12; e++) begin
      if (e == abort_at) begin
        ss = 1'b0; mosi = 1'b0;
        repeat (HALF) @(negedge clk);
        return;
      end
      if (e == 1)       mosi = 1'b1;
      else if (e == 2)  mosi = rd;
      else if (e == 3)  mosi = sel;
      else if (e <= 11) mosi = wb[11-e];
      else              mosi = 1'b0;
      repeat (HALF) @(negedge clk);
      if (e >= 4 && e <= 11) rb[11-e] = miso;
      if (e == 12) st = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      if (e == 11) early = miso;
      sclk = 1'b0;
    end
    st_hold = (early == st);
    mosi = 1'b0; ss = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic lpush(input logic [7:0] d);
    @(negedge clk); tx_push = 1'b1; tx_wdata = d;
    @(negedge clk); tx_push = 1'b0;
  endtask

  task automatic lpop();
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
  endtask

  task automatic do_read(input string req, input bit sel, input logic [7:0] eb, input logic es);
    logic [7:0] b; logic s, h;
    xfer(1'b1, sel, 8'h00, 0, b, s, h);
    chk({req, " read byte"}, 32'(b), 32'(eb));
    chk({req, " read handshake"}, 32'(s), 32'(es));
    chk("R9 handshake held", 32'(h), 32'd1);
    chk("R9 miso idle", 32'(miso), 32'd0);
  endtask

  task automatic do_write(input string req, input bit sel, input logic [7:0] wb, input logic es);
    logic [7:0] b; logic s, h;
    xfer(1'b0, sel, wb, 0, b, s, h);
    chk({req, " write handshake"}, 32'(s), 32'(es));
    chk("R9 handshake held", 32'(h), 32'd1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] b; logic s, h;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 miso", 32'(miso), 32'd0);
    chk("R1 tx_full", 32'(tx_full), 32'd0);
    chk("R1 rx_empty", 32'(rx_empty), 32'd1);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][19:18])
        2'd0: lpush(VEC[i][17:10]);
        2'd1: do_read("R3/R4", 1'b0, VEC[i][9:2], VEC[i][1]);
        2'd2: do_write("R5", 1'b0, VEC[i][17:10], VEC[i][1]);
        default: begin
          chk("R5 rx order", 32'(rx_rdata), 32'(VEC[i][9:2]));
          lpop();
        end
      endcase
    end
    chk("R5 rx drained", 32'(rx_empty), 32'd1);

    // R2: idle edges without a valid start do nothing
    ss = 1'b1; mosi = 1'b0;
    for (int k = 0; k < 3; k++) begin
      repeat (HALF) @(negedge clk); sclk = 1'b1;
      repeat (HALF) @(negedge clk); sclk = 1'b0;
      chk("R2 no start with mosi low", 32'(miso), 32'd0);
    end
    ss = 1'b0; mosi = 1'b1;
    for (int k = 0; k < 2; k++) begin
      repeat (HALF) @(negedge clk); sclk = 1'b1;
      repeat (HALF) @(negedge clk); sclk = 1'b0;
      chk("R2 no start with ss low", 32'(miso), 32'd0);
    end
    mosi = 1'b0;
    repeat (HALF) @(negedge clk);
    lpush(8'h11);
    do_read("R2", 1'b0, 8'h11, 1'b0);

    // R7 status byte
    do_read("R7 empty", 1'b1, 8'h00, 1'b0);
    lpush(8'h22);
    do_read("R7 tx avail", 1'b1, 8'h01, 1'b0);
    do_read("R7 no pop", 1'b0, 8'h22, 1'b0);

    // R6 fill receive queue, then refuse
    for (int k = 0; k < 4; k++) do_write("R5 fill", 1'b0, 8'h81 + 8'(k), 1'b0);
    do_write("R6 full", 1'b0, 8'h85, 1'b1);
    do_read("R7 rx full", 1'b1, 8'h02, 1'b0);
    for (int k = 0; k < 4; k++) begin
      chk("R6 contents kept", 32'(rx_rdata), 32'(8'h81 + 8'(k)));
      lpop();
    end
    chk("R6 nothing extra", 32'(rx_empty), 32'd1);

    // R8 write to status select
    do_write("R8", 1'b1, 8'h99, 1'b1);
    chk("R8 no push", 32'(rx_empty), 32'd1);

    // R11 pop on empty ignored
    lpop();
    do_write("R11", 1'b0, 8'h44, 1'b0);
    chk("R11 rx head", 32'(rx_rdata), 32'h44);
    lpop();
    chk("R11 rx empty", 32'(rx_empty), 32'd1);

    // R10 aborted read then aborted write
    lpush(8'h77);
    xfer(1'b1, 1'b0, 8'h00, 7, b, s, h);
    chk("R10 miso after abort", 32'(miso), 32'd0);
    do_read("R10 no pop", 1'b0, 8'h77, 1'b0);
    do_read("R10 repeat", 1'b0, 8'h77, 1'b1);
    xfer(1'b0, 1'b0, 8'hEE, 9, b, s, h);
    chk("R10 no push", 32'(rx_empty), 32'd1);

    // R11 push into full transmit queue
    for (int k = 1; k <= 5; k++) lpush(8'(k));
    chk("R11 tx_full", 32'(tx_full), 32'd1);
    for (int k = 1; k <= 4; k++) do_read("R11 order", 1'b0, 8'(k), 1'b0);
    chk("R11 tx not full", 32'(tx_full), 32'd0);
    do_read("R11 fifth dropped", 1'b0, 8'h04, 1'b1);

    finish_run();
  end
endmodule